// File: doc/BRIEF.md
# SPI Potentiometer Command Decoder

This block is the serial front end of a single-wiper digital potentiometer. It holds sixteen 8-bit data registers, arranged as four banks of four, and the 8-bit wiper register that sets the tap position. A host addresses the device over a four-wire serial bus: SPI mode 0, most significant bit first.

Each transaction begins when chip select falls. The first byte is an address byte. It carries a fixed device-type nibble and the two address bits that must match the strap pins. The second byte is a command byte, and it selects an opcode, a register and a bank. Some commands use a third byte, which either returns a value or supplies one.

The serial inputs are resynchronised to the system clock, so the serial clock must be several times slower than `clk`. The `miso` line is only valid while `miso_oe` is high. The pad drives `miso` when `miso_oe` is high and floats it otherwise.

Top module: `spi_pot_decoder`

## Requirements
- R1: After reset, `wiper` is 0, all sixteen data registers read as 0, and `miso_oe` is low.
- R2: A transaction proceeds only if bits 7:4 of the address byte equal 4'b0101. Any other value makes the rest of the transaction have no effect.
- R3: In the address byte, bits 1:0 must equal `strap_addr` (bit 1 on the left) and bits 3:2 must be 0. Otherwise the rest of the transaction has no effect.
- R4: The command byte has the layout {opcode[7:4], reg[3:2], bank[1:0]}, and it selects register bank*4+reg. Opcode 4'hC writes the third byte into that register. Opcode 4'hB returns that register's value on the third byte, most significant bit first, with the first bit present before the first rising edge of that byte.
- R5: Opcode 4'hA writes the third byte into the wiper register. Opcode 4'h9 returns the wiper register on the third byte.
- R6: Opcode 4'hD copies the selected bank-0 register into the wiper register. Opcode 4'hE copies the wiper register into the selected bank-0 register. Both complete at the end of the command byte.
- R7: Opcodes 4'hD and 4'hE with a nonzero bank field have no effect.
- R8: Opcodes other than 4'h9 to 4'hE have no effect, even when a third byte follows.
- R9: A write commits only after all 8 bits of the third byte have arrived. Raising `cs_n` earlier, at any point, discards the partial transaction, and the next transaction starts again with an address byte.
- R10: `miso_oe` is high only during the third byte of an accepted read. It is low while the device is deselected and during every other byte.
- R11: The sixteen data registers are independent. A write to one register leaves the other fifteen and the wiper register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| strap_addr | input | 2 | Pin-strapped device address |
| miso | output | 1 | Serial data out, valid while miso_oe is high |
| miso_oe | output | 1 | Output enable for the miso pad |
| wiper | output | 8 | Current wiper register value |

## Verification
The bench writes a distinct value into every one of the sixteen registers and reads each one back. This shows whether the bank and register fields are swapped or aliased. Two things separate bank-0 transfers from ignored ones: copies with banks 1 and 3, and copies with different register fields. Address bytes with a wrong type nibble, a wrong strap value or nonzero reserved bits are each sent after the strap pins change, so each gating condition is tried on its own. Third bytes cut off after a few bits, and transactions cut off inside the command byte, show whether a write commits early. They also show whether the framing restarts cleanly.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
   localparam int BYTE_W      = 8;
   localparam int FIELD_W     = 2;
   localparam int N_REG       = (1 << FIELD_W) * (1 << FIELD_W);
   localparam int IDX_W       = 2 * FIELD_W;

   localparam logic [3:0] OP_RD_WIP  = 4'h9;
   localparam logic [3:0] OP_WR_WIP  = 4'hA;
   localparam logic [3:0] OP_RD_REG  = 4'hB;
   localparam logic [3:0] OP_WR_REG  = 4'hC;
   localparam logic [3:0] OP_REG2WIP = 4'hD;
   localparam logic [3:0] OP_WIP2REG = 4'hE;

   typedef enum logic [2:0] {
      FR_ADDR, FR_CMD, FR_READ, FR_WRITE, FR_SKIP
   } frame_st_e;
endpackage

// File: rtl/spi_pot_serial.sv
module spi_pot_serial #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   input  logic       tx_shift_en,
   output logic       cs_act,
   output logic       rx_done,
   output logic [7:0] rx_byte,
   output logic       sclk_fall,
   output logic       miso_bit
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0][2:0] stg;   // {cs_n, sclk, mosi}
   logic       sclk_d;
   logic [6:0] rx_sh;
   logic [2:0] bit_cnt;
   logic [7:0] tx_sh;
   logic       sclk_s, mosi_s, sclk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg    <= {SYNC_STAGES{3'b100}};
         sclk_d <= 1'b0;
      end else begin
         stg    <= {stg[SYNC_STAGES-2:0], {cs_n, sclk, mosi}};
         sclk_d <= sclk_s;
      end
   end

   assign cs_act    = ~stg[TOP][2];
   assign sclk_s    = stg[TOP][1];
   assign mosi_s    = stg[TOP][0];
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign rx_done   = cs_act & sclk_rise & (bit_cnt == 3'd7);
   assign rx_byte   = {rx_sh, mosi_s};
   assign miso_bit  = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh   <= '0;
         bit_cnt <= '0;
      end else if (!cs_act) begin
         rx_sh   <= '0;
         bit_cnt <= '0;
      end else if (sclk_rise) begin
         rx_sh   <= {rx_sh[5:0], mosi_s};
         bit_cnt <= bit_cnt + 3'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_sh <= '0;
      else if (tx_load)
         tx_sh <= tx_byte;
      else if (sclk_fall && tx_shift_en && bit_cnt != 3'd0)
         tx_sh <= {tx_sh[6:0], 1'b0};
   end
endmodule

// File: rtl/spi_pot_frame.sv
module spi_pot_frame
   import spi_pot_pkg::*;
#(
   parameter logic [3:0] DEV_TYPE = 4'b0101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_act,
   input  logic             rx_done,
   input  logic [7:0]       rx_byte,
   input  logic [1:0]       strap_addr,
   input  logic [7:0]       reg_q,
   input  logic [7:0]       wiper_q,
   output logic [IDX_W-1:0] rd_idx,
   output logic             rd_phase,
   output logic             tx_load,
   output logic [7:0]       tx_byte,
   output logic             reg_we,
   output logic             wip_we,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data
);
   frame_st_e        st, st_nx;
   logic             to_wip_q, to_wip_nx;
   logic [IDX_W-1:0] idx_q, idx_nx;
   logic             addr_ok, bank0;
   logic [3:0]       op;

   assign op      = rx_byte[7:4];
   assign rd_idx  = {rx_byte[1:0], rx_byte[3:2]};
   assign bank0   = (rx_byte[1:0] == 2'b00);
   assign addr_ok = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:2] == 2'b00)
                    && (rx_byte[1:0] == strap_addr);
   assign rd_phase = (st == FR_READ);

   always_comb begin
      st_nx     = st;
      to_wip_nx = to_wip_q;
      idx_nx    = idx_q;
      tx_load   = 1'b0;
      tx_byte   = reg_q;
      reg_we    = 1'b0;
      wip_we    = 1'b0;
      wr_idx    = idx_q;
      wr_data   = rx_byte;
      if (rx_done) begin
         unique case (st)
            FR_ADDR: st_nx = addr_ok ? FR_CMD : FR_SKIP;
            FR_CMD: begin
               st_nx  = FR_SKIP;
               idx_nx = rd_idx;
               wr_idx = rd_idx;
               case (op)
                  OP_RD_WIP: begin st_nx = FR_READ; tx_load = 1'b1; tx_byte = wiper_q; end
                  OP_RD_REG: begin st_nx = FR_READ; tx_load = 1'b1; end
                  OP_WR_WIP: begin st_nx = FR_WRITE; to_wip_nx = 1'b1; end
                  OP_WR_REG: begin st_nx = FR_WRITE; to_wip_nx = 1'b0; end
                  OP_REG2WIP: begin wip_we = bank0; wr_data = reg_q; end
                  OP_WIP2REG: begin reg_we = bank0; wr_data = wiper_q; end
                  default: ;
               endcase
            end
            FR_WRITE: begin
               st_nx  = FR_SKIP;
               wip_we = to_wip_q;
               reg_we = ~to_wip_q;
            end
            FR_READ:  st_nx = FR_SKIP;
            default:  st_nx = FR_SKIP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FR_ADDR;
         to_wip_q <= 1'b0;
         idx_q    <= '0;
      end else if (!cs_act) begin
         st       <= FR_ADDR;
      end else begin
         st       <= st_nx;
         to_wip_q <= to_wip_nx;
         idx_q    <= idx_nx;
      end
   end
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs
   import spi_pot_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             wip_we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic [7:0]       wiper
);
   logic [7:0] bank_mem [N_REG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_REG; i++) bank_mem[i] <= '0;
         wiper <= '0;
      end else begin
         if (reg_we) bank_mem[wr_idx] <= wr_data;
         if (wip_we) wiper <= wr_data;
      end
   end

   assign rd_data = bank_mem[rd_idx];
endmodule

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder
   import spi_pot_pkg::*;
#(
   parameter logic [3:0] DEV_TYPE    = 4'b0101,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic [1:0] strap_addr,
   output logic       miso,
   output logic       miso_oe,
   output logic [7:0] wiper
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("byte framing assumes 8-bit bytes");
   end

   logic             cs_act, rx_done, sclk_fall, miso_bit;
   logic [7:0]       rx_byte, tx_byte, reg_q, wr_data;
   logic             tx_load, rd_phase, reg_we, wip_we;
   logic [IDX_W-1:0] rd_idx, wr_idx;

   spi_pot_serial #(.SYNC_STAGES(SYNC_STAGES)) u_serial (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .tx_load(tx_load), .tx_byte(tx_byte), .tx_shift_en(rd_phase),
      .cs_act(cs_act), .rx_done(rx_done), .rx_byte(rx_byte),
      .sclk_fall(sclk_fall), .miso_bit(miso_bit)
   );

   spi_pot_frame #(.DEV_TYPE(DEV_TYPE)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_done(rx_done),
      .rx_byte(rx_byte), .strap_addr(strap_addr), .reg_q(reg_q),
      .wiper_q(wiper), .rd_idx(rd_idx), .rd_phase(rd_phase),
      .tx_load(tx_load), .tx_byte(tx_byte), .reg_we(reg_we),
      .wip_we(wip_we), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   spi_pot_regs u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .wip_we(wip_we),
      .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
      .rd_data(reg_q), .wiper(wiper)
   );

   assign miso_oe = rd_phase;
   assign miso    = rd_phase & miso_bit;
endmodule

// File: rtl/spi_pot_chk.sv
module spi_pot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       rx_done,
   input logic       sclk_fall,
   input logic       miso,
   input logic       miso_oe,
   input logic [7:0] wiper
);
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wiper == 8'd0 && !miso_oe));

   // R6: the wiper moves only on a completed byte
   p_wiper_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper != $past(wiper)) |-> $past(rx_done));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !$past(cs_act)) |-> (wiper == $past(wiper)));

   p_oe_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(rx_done));

   p_oe_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
      miso_oe |-> $past(cs_act));

   p_shift_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && miso != $past(miso)) |-> $past(sclk_fall));
endmodule

bind spi_pot_decoder spi_pot_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_done(rx_done),
   .sclk_fall(sclk_fall), .miso(miso), .miso_oe(miso_oe), .wiper(wiper)
);

// File: tb/sim_spi_pot_decoder.sv
`timescale 1ns/1ps
module sim_spi_pot_decoder;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic [1:0] strap = 2'b00;
   logic miso, miso_oe;
   logic [7:0] wiper;
   int vectors = 0, miscompares = 0;
   bit settled = 1'b0;
   bit done = 1'b0;

   int m_reg [16];
   int m_wip = 0;

   always #4 clk = ~clk;

   spi_pot_decoder u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .strap_addr(strap), .miso(miso), .miso_oe(miso_oe), .wiper(wiper)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison while idle: wiper follows model, output disabled
   always @(negedge clk) begin
      if (settled && !done) begin
         check(wiper === m_wip[7:0], "R5/R6 idle wiper", wiper, m_wip);
         check(miso_oe === 1'b0, "R10 idle oe", miso_oe, 0);
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // send nbits of {id, ins, dat}; check third byte, then update model
   task automatic txn(input logic [7:0] id, input logic [7:0] ins,
                      input logic [7:0] dat, input int nbits, input string req);
      logic [23:0] fr;
      logic [7:0]  got;
      bit oe_all, oe_any, acc, is_rd;
      int op, idx, bank, exp_val;
      fr = {id, ins, dat};
      got = '0; oe_all = 1'b1; oe_any = 1'b0;
      op = ins[7:4]; bank = ins[1:0]; idx = bank * 4 + ins[3:2];
      acc = (id[7:4] == 4'b0101) && (id[3:2] == 2'b00) && (id[1:0] == strap);
      is_rd = acc && (op == 9 || op == 11);
      exp_val = (op == 9) ? m_wip : m_reg[idx];
      settled = 1'b0;
      @(negedge clk); cs_n = 1'b0; wait_n(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = fr[23-i]; wait_n(HALF);
         if (i >= 16) begin
            got[23-i] = miso;
            oe_all &= miso_oe;
            oe_any |= miso_oe;
         end
         sclk = 1'b1; wait_n(HALF);
         sclk = 1'b0;
      end
      wait_n(HALF); cs_n = 1'b1; wait_n(6);
      if (nbits == 24) begin
         if (is_rd) begin
            check(oe_all, {req, " read oe"}, oe_all, 1);
            check(got == exp_val[7:0], {req, " read data"}, got, exp_val);
         end else
            check(!oe_any, {req, " R10 oe on non-read"}, oe_any, 0);
      end
      if (acc && nbits >= 16) begin
         if (op == 13 && bank == 0) m_wip = m_reg[idx];
         if (op == 14 && bank == 0) m_reg[idx] = m_wip;
         if (nbits >= 24 && op == 10) m_wip = dat;
         if (nbits >= 24 && op == 12) m_reg[idx] = dat;
      end
      settled = 1'b1;
   endtask

   function automatic logic [7:0] cmd(input int op, input int bank, input int ptr);
      return {op[3:0], ptr[1:0], bank[1:0]};
   endfunction

   function automatic logic [7:0] idb(input logic [1:0] a);
      return {4'b0101, 2'b00, a};
   endfunction

   task automatic read_all(input string req);
      for (int b = 0; b < 4; b++)
         for (int p = 0; p < 4; p++)
            txn(idb(strap), cmd(11, b, p), 8'h00, 24, req);
      txn(idb(strap), cmd(9, 0, 0), 8'h00, 24, req);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) m_reg[i] = 0;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      check(wiper === 8'd0, "R1 reset wiper", wiper, 0);
      check(miso_oe === 1'b0, "R1 reset oe", miso_oe, 0);
      settled = 1'b1;
      read_all("R1 reset regs");

      // R4 R11: distinct value in every register, then read all back
      for (int b = 0; b < 4; b++)
         for (int p = 0; p < 4; p++)
            txn(idb(strap), cmd(12, b, p), 8'(8'h11 * (b * 4 + p) + 8'h03), 24, "R4 write");
      read_all("R4 R11 readback");

      // R5 wiper write/read
      txn(idb(strap), cmd(10, 0, 0), 8'h5A, 24, "R5 write wiper");
      txn(idb(strap), cmd(9, 0, 0), 8'h00, 24, "R5 read wiper");

      // R6 transfers on bank 0
      txn(idb(strap), cmd(13, 0, 2), 8'h00, 16, "R6 reg2wip");
      txn(idb(strap), cmd(10, 0, 0), 8'hC3, 24, "R6 set wiper");
      txn(idb(strap), cmd(14, 0, 1), 8'h00, 16, "R6 wip2reg");
      txn(idb(strap), cmd(11, 0, 1), 8'h00, 24, "R6 readback");

      // R7 transfers with nonzero bank ignored
      txn(idb(strap), cmd(13, 1, 3), 8'h00, 16, "R7 reg2wip bank1");
      txn(idb(strap), cmd(14, 3, 0), 8'h00, 16, "R7 wip2reg bank3");
      txn(idb(strap), cmd(11, 3, 0), 8'h00, 24, "R7 readback");

      // R8 undefined opcodes
      txn(idb(strap), cmd(3, 0, 0), 8'hFF, 24, "R8 op3");
      txn(idb(strap), cmd(15, 0, 0), 8'h00, 24, "R8 opF");
      txn(idb(strap), cmd(8, 1, 1), 8'h77, 24, "R8 op8");

      // R2 R3 address gating
      strap = 2'b10;
      txn(8'h62, cmd(10, 0, 0), 8'h11, 24, "R2 bad type");
      txn(idb(2'b01), cmd(10, 0, 0), 8'h22, 24, "R3 bad strap");
      txn(8'h56, cmd(12, 0, 0), 8'h33, 24, "R3 reserved bits");
      txn(idb(2'b10), cmd(10, 0, 0), 8'h44, 24, "R3 match");
      strap = 2'b11;
      txn(idb(2'b10), cmd(12, 2, 2), 8'h55, 24, "R3 old strap");
      txn(idb(2'b11), cmd(10, 0, 0), 8'h66, 24, "R3 new strap");
      read_all("R2 R3 readback");

      // R9 aborted transactions
      txn(idb(strap), cmd(10, 0, 0), 8'h99, 21, "R9 short wiper write");
      txn(idb(strap), cmd(12, 1, 2), 8'h99, 23, "R9 short reg write");
      txn(idb(strap), cmd(13, 0, 0), 8'h00, 12, "R9 cut in cmd");
      txn(idb(strap), 8'h00, 8'h00, 4, "R9 cut in addr");
      txn(idb(strap), cmd(9, 0, 0), 8'h00, 24, "R9 after abort");
      txn(idb(strap), cmd(11, 1, 2), 8'h00, 24, "R9 reg intact");
      txn(idb(strap), cmd(12, 1, 2), 8'hA5, 24, "R9 full write");
      read_all("R9 R11 final");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule